// File: doc/BRIEF.md
# Programmable Tick Timer

A free-running tick counter on the processor clock that raises a maskable interrupt when its low bits reach a programmed period. Software talks to it over a small register bus with two addresses. Address 0 is a control word that holds a 2-bit operating mode, an interrupt enable, a sticky pending flag and the period. Address 1 is the full-width count, which software can both read and overwrite.

Four modes decide what a period match does to the counter. The counter can be stopped, restarted from zero, halted until software reloads it, or left running through its whole range. The comparison uses only the low `DATA_W-4` bits of the count, so in continuous mode the upper bits extend the count beyond the period range. The interrupt line is the pending flag gated by the enable bit.

Top module: `tick_timer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rdata` is 0 and `irq` is 0. Reset clears the control word and the count to 0.
- R2: In mode 2'b00 (off) the count holds its value and no match is ever detected.
- R3: In any nonzero mode, unless R5, R6 or R11 applies, the count increases by exactly 1 each clock.
- R4: A match exists when the mode is nonzero and count bits [DATA_W-5:0] equal the period field. Count bits above that range do not take part.
- R5: In mode 2'b01 (restart), a match makes the count 0 on the next clock, and counting then continues.
- R6: In mode 2'b10 (one-shot), a match freezes the count. It moves again only after software writes address 1.
- R7: In mode 2'b11 (continuous), a match changes nothing in the counter, and the count wraps from all ones to 0.
- R8: A match sets the pending flag, which is bit DATA_W-4 of the control word, on the next clock.
- R9: `irq` is high exactly when both the pending flag and the enable bit (bit DATA_W-3) are set.
- R10: A write to address 0 with bit DATA_W-4 at 0 clears the pending flag. Writing a 1 there never sets it, and a match in the same cycle as a clear leaves it set.
- R11: A write to address 1 loads `wdata` into the count, taking priority over increment, restart and halt in that cycle.
- R12: `rdata` is registered. One clock after `addr` is presented it shows the count (addr 1) or the control word (addr 0) laid out as {mode[DATA_W-1:DATA_W-2], enable, pending, period[DATA_W-5:0]}. The value shown is the one from before that clock's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control word, 1 count |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Tick interrupt request |

## Verification
The bench builds the timer with DATA_W = 16, which gives a 12-bit period and a 16-bit count. With this width, letting continuous mode run through a full natural lap of the count takes only 65,536 cycles. Count values with the upper four bits set show that those bits are left out of the match. Loading the count just below all ones reaches the wrap point directly. Same-cycle collisions, such as a match together with a pending-clear write, are lined up by reloading the count so that it meets the period on a chosen cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    TM_OFF     = 2'b00,
    TM_RESTART = 2'b01,
    TM_ONESHOT = 2'b10,
    TM_FREE    = 2'b11
  } tmode_e;
endpackage

// File: rtl/tick_cmp.sv
module tick_cmp
  import tick_timer_pkg::*;
#(
  parameter int PER_W = 28
) (
  input  tmode_e           mode,
  input  logic [PER_W-1:0] count_lo,
  input  logic [PER_W-1:0] period,
  output logic             hit
);
  always_comb hit = (mode != TM_OFF) && (count_lo == period);
endmodule

// File: rtl/tick_ctrl_reg.sv
module tick_ctrl_reg
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit,
  output tmode_e            mode,
  output logic              ien,
  output logic              pend,
  output logic [DATA_W-5:0] period
);
  localparam int PEND_B = DATA_W - 4;
  localparam int IEN_B  = DATA_W - 3;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= TM_OFF;
      ien    <= 1'b0;
      pend   <= 1'b0;
      period <= '0;
    end else begin
      if (wr_en) begin
        mode   <= tmode_e'(wdata[DATA_W-1:DATA_W-2]);
        ien    <= wdata[IEN_B];
        period <= wdata[PEND_B-1:0];
      end
      // a match wins over a clear; writing 1 never sets the flag
      pend <= hit | (wr_en ? (pend & wdata[PEND_B]) : pend);
    end
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  tmode_e            mode,
  input  logic              hit,
  output logic [DATA_W-1:0] count
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    unique case (mode)
      TM_OFF:     nxt = count;
      TM_RESTART: nxt = hit ? '0 : count + 1'b1;
      TM_ONESHOT: nxt = hit ? count : count + 1'b1;
      TM_FREE:    nxt = count + 1'b1;
      default:    nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= wdata;
    else           count <= nxt;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int PER_W = DATA_W - 4;

  tmode_e            tmode;
  logic              ien;
  logic              pend;
  logic [PER_W-1:0]  period;
  logic [DATA_W-1:0] count;
  logic              hit;
  logic              ctrl_wr;
  logic              cnt_wr;

  assign ctrl_wr = we & ~addr;
  assign cnt_wr  = we & addr;

  tick_cmp #(.PER_W(PER_W)) u_cmp (
    .mode(tmode), .count_lo(count[PER_W-1:0]), .period(period), .hit(hit)
  );

  tick_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(ctrl_wr), .wdata(wdata), .hit(hit),
    .mode(tmode), .ien(ien), .pend(pend), .period(period)
  );

  tick_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_wr), .wdata(wdata), .mode(tmode),
    .hit(hit), .count(count)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= addr ? count : {tmode, ien, pend, period};
  end

  assign irq = pend & ien;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              we,
  input logic              addr,
  input logic [DATA_W-1:0] wdata,
  input logic [1:0]        mode,
  input logic              hit,
  input logic              pend,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] rdata,
  input logic              irq
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (rdata == '0 && !irq));
  // R2
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && !(we && addr)) |=> $stable(count));
  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && hit && !(we && addr)) |=> (count == '0));
  // R6
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && hit && !(we && addr)) |=> $stable(count));
  // R7
  free_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && !(we && addr)) |=> (count == DATA_W'($past(count) + 1'b1)));
  // R8
  match_pend_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> pend);
  // R10
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !addr && !wdata[DATA_W-4] && !hit) |=> !pend);
  // R11
  load_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr) |=> (count == $past(wdata)));
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata), .mode(tmode),
  .hit(hit), .pend(pend), .count(count), .rdata(rdata), .irq(irq)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  localparam int DW = 16;
  localparam int PW = DW - 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we = 1'b0;
  logic          addr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // reference model state
  logic [1:0]    m_mode = 2'b00;
  logic          m_ien = 1'b0;
  logic          m_pend = 1'b0;
  logic [PW-1:0] m_per = '0;
  logic [DW-1:0] m_cnt = '0;
  logic [DW-1:0] e_rd = '0;

  tick_timer #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (time %0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] cw(input logic [1:0] md, input logic ie,
                                       input logic pd, input int per);
    return {md, ie, pd, PW'(per)};
  endfunction

  // behavioural model, one step per clock
  always @(posedge clk) begin
    logic m;
    logic [DW-1:0] nc;
    cycles++;
    if (rst) begin
      m_mode = 2'b00; m_ien = 1'b0; m_pend = 1'b0; m_per = '0; m_cnt = '0; e_rd = '0;
    end else begin
      m = (m_mode != 2'b00) && (m_cnt % (1 << PW) == DW'(m_per));
      e_rd = addr ? m_cnt : {m_mode, m_ien, m_pend, m_per};
      if (m_mode == 2'b00)                nc = m_cnt;
      else if (m_mode == 2'b01 && m)      nc = '0;
      else if (m_mode == 2'b10 && m)      nc = m_cnt;
      else                                nc = m_cnt + 1;
      if (we && addr) nc = wdata;
      if (we && !addr) begin
        m_pend = m || (m_pend && wdata[PW]);
        m_mode = wdata[DW-1:DW-2];
        m_ien  = wdata[DW-3];
        m_per  = wdata[PW-1:0];
      end else begin
        m_pend = m || m_pend;
      end
      m_cnt = nc;
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    chk(cur_req, rdata, e_rd);
    chk(cur_req, DW'(irq), DW'(m_pend & m_ien));
  end

  task automatic wr(input logic a, input logic [DW-1:0] d);
    @(posedge clk); #2;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    we = 1'b0;
  endtask

  task automatic run(input int n, input logic a);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      we = 1'b0; addr = a;
    end
  endtask

  task automatic run_alt(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      we = 1'b0; addr = i[0];
    end
  endtask

  task automatic spot(input string req, input logic a, input logic [DW-1:0] exp);
    @(posedge clk); #2; we = 1'b0; addr = a;
    @(posedge clk); #6;
    chk(req, rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #6;
    chk("R1", rdata, '0);
    chk("R1", DW'(irq), '0);
    #0 rst = 1'b0;
    @(posedge clk); #6;
    chk("R1", rdata, '0);
    chk("R1", DW'(irq), '0);

    // R2: off mode, count stays where it was loaded
    cur_req = "R2";
    wr(1'b1, 16'd5);
    run(10, 1'b1);
    spot("R2", 1'b1, 16'd5);

    // R3 / R8 / R9: continuous with enable, period 20
    cur_req = "R3";
    wr(1'b0, cw(2'b11, 1'b1, 1'b0, 20));
    run_alt(12);
    cur_req = "R8";
    run(12, 1'b0);
    spot("R9", 1'b0, cw(2'b11, 1'b1, 1'b1, 20));
    chk("R9", DW'(irq), 16'd1);

    // R10: clear, then writing 1 does not set
    cur_req = "R10";
    wr(1'b0, cw(2'b11, 1'b1, 1'b0, 20));
    spot("R10", 1'b0, cw(2'b11, 1'b1, 1'b0, 20));
    wr(1'b0, cw(2'b11, 1'b1, 1'b1, 20));
    spot("R10", 1'b0, cw(2'b11, 1'b1, 1'b0, 20));
    // match and clear on the same clock: flag stays set
    wr(1'b1, 16'd19);
    wr(1'b0, cw(2'b11, 1'b1, 1'b0, 20));
    spot("R10", 1'b0, cw(2'b11, 1'b1, 1'b1, 20));

    // R4: upper count bits ignored by the match
    cur_req = "R4";
    wr(1'b0, cw(2'b11, 1'b1, 1'b0, 7));
    wr(1'b1, 16'hA005);
    run(6, 1'b1);
    spot("R4", 1'b0, cw(2'b11, 1'b1, 1'b1, 7));

    // R7: wrap at all ones, then one full natural lap
    cur_req = "R7";
    wr(1'b1, 16'hFFFD);
    run(6, 1'b1);
    run(65536, 1'b1);

    // R5: restart mode, period 10
    cur_req = "R5";
    wr(1'b0, cw(2'b01, 1'b0, 1'b0, 10));
    wr(1'b1, 16'd0);
    run_alt(40);

    // R6: one-shot halts at 8, resumes after reload
    cur_req = "R6";
    wr(1'b0, cw(2'b10, 1'b1, 1'b0, 8));
    wr(1'b1, 16'd0);
    run(20, 1'b1);
    spot("R6", 1'b1, 16'd8);
    wr(1'b1, 16'd2);
    run(3, 1'b1);
    run(15, 1'b1);

    // R9: masked interrupt, flag still records the match
    cur_req = "R9";
    wr(1'b0, cw(2'b11, 1'b0, 1'b0, 30));
    wr(1'b1, 16'd28);
    run(5, 1'b0);
    spot("R9", 1'b0, cw(2'b11, 1'b0, 1'b1, 30));
    chk("R9", DW'(irq), 16'd0);

    // R11: back-to-back loads beat restart and increment
    cur_req = "R11";
    wr(1'b0, cw(2'b01, 1'b1, 1'b0, 4));
    @(posedge clk); #2; we = 1'b1; addr = 1'b1; wdata = 16'd4;
    @(posedge clk); #2; wdata = 16'd4;
    @(posedge clk); #2; wdata = 16'h0100;
    @(posedge clk); #2; we = 1'b0;
    run(4, 1'b1);

    // R12: alternating reads of both addresses
    cur_req = "R12";
    run_alt(16);

    run(3, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule